// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU with Register Shifter

This block is the combinational data-processing unit of a compact 16-bit-instruction processor core. Each cycle it receives a 4-bit operation code, the destination register value, the source register value and the current N, Z, C and V condition flags. It returns the new destination value, a strobe saying whether that value should be written back, and the updated flags. The register file, the decoder and any clocking around the unit sit outside it.

The unit handles bitwise logic, add and subtract with carry, negate, flag-only compares, and the four shifts and rotates whose amount comes from a register. Register shifts are where most of the corner cases are. The amount is the low byte of the source operand. Amounts of zero, 1 to 31, exactly 32 and above 32 each have their own rules for the result and the carry. Multiply is handled elsewhere. For that code the unit only raises a request line and leaves everything else untouched.

Top module: `alu_core`

## Requirements
- R1: Opcodes 0 (AND), 1 (EOR), C (ORR), E (BIC: dest AND NOT src) and F (MVN: NOT src) write their result. N becomes result bit 31 and Z is set when the result is zero. C and V keep their input values.
- R2: Opcode 8 (TST) writes nothing. It sets N and Z from dest AND src and keeps C and V.
- R3: Opcode 5 (ADC) writes dest + src + C. C becomes the unsigned carry-out. V is set when both addends share a sign that the sum lacks.
- R4: Opcode 6 (SBC) writes dest − src − (1 − C), and opcode 9 (NEG) writes 0 − src. After a subtraction C is 1 exactly when no borrow occurred, and V flags signed overflow.
- R5: Opcodes A (CMP, dest − src) and B (CMN, dest + src) update N, Z, C and V as the matching subtraction or addition but write nothing. Whenever nothing is written, result_o equals dst_i.
- R6: Opcodes 2 (LSL), 3 (LSR), 4 (ASR) and 7 (ROR) take their amount from src bits [7:0] and ignore src bits [31:8]. An amount of zero returns dest unchanged with C unchanged.
- R7: LSL by 1..31 shifts left, and C is the last bit shifted out. LSL by 32 gives 0 with C = dest bit 0. LSL by more than 32 gives 0 with C = 0.
- R8: LSR by 1..31 shifts right with zero fill, and C is the last bit shifted out. LSR by 32 gives 0 with C = dest bit 31. LSR by more than 32 gives 0 with C = 0.
- R9: ASR by 1..31 shifts right with sign fill, and C is the last bit shifted out. ASR by 32 or more fills every result bit and C with dest bit 31.
- R10: ROR by a nonzero amount whose low five bits are zero returns dest unchanged with C = dest bit 31. Otherwise it rotates right by the amount mod 32, and C is the last bit rotated out.
- R11: Opcode D raises mul_req_o, writes nothing and leaves all four flags unchanged. mul_req_o is low for every other opcode.
- R12: Every written result drives N and Z from that result. All shifts keep V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| dst_i | input | 32 | Destination operand (current register value) |
| src_i | input | 32 | Source operand; low byte is the shift amount |
| n_i | input | 1 | Current negative flag |
| z_i | input | 1 | Current zero flag |
| c_i | input | 1 | Current carry flag |
| v_i | input | 1 | Current overflow flag |
| result_o | output | 32 | New destination value |
| wr_en_o | output | 1 | Result should be written back |
| n_o | output | 1 | Updated negative flag |
| z_o | output | 1 | Updated zero flag |
| c_o | output | 1 | Updated carry flag |
| v_o | output | 1 | Updated overflow flag |
| mul_req_o | output | 1 | Multiply requested from the separate unit |

## Verification
The embedded assertions check several rules on every evaluation:
- compare and multiply codes never write, and a suppressed write passes dst_i through;
- multiply keeps all flags;
- logical and shift codes keep V;
- N and Z agree with any written result;
- a zero shift amount changes neither the value nor the carry.

Only the bench's scenarios can show the arithmetic that determines the values themselves. That covers the exact carry and overflow of each add or subtract form. It also covers the carry bit picked at shift amounts 1, 31, 32, 33 and 255, and rotate amounts that are multiples of 32. The bench compares these against a bit-serial reference on every clock.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OPC_AND = 4'h0,
    OPC_EOR = 4'h1,
    OPC_LSL = 4'h2,
    OPC_LSR = 4'h3,
    OPC_ASR = 4'h4,
    OPC_ADC = 4'h5,
    OPC_SBC = 4'h6,
    OPC_ROR = 4'h7,
    OPC_TST = 4'h8,
    OPC_NEG = 4'h9,
    OPC_CMP = 4'hA,
    OPC_CMN = 4'hB,
    OPC_ORR = 4'hC,
    OPC_MUL = 4'hD,
    OPC_BIC = 4'hE,
    OPC_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2,
    SH_ROT   = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    unique case (op)
      OPC_EOR: y = a ^ b;
      OPC_ORR: y = a | b;
      OPC_BIC: y = a & ~b;
      OPC_MVN: y = ~b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  shift_kind_e   kind,
  input  logic [W-1:0]  d,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  y,
  output logic          cout
);
  localparam int LW = $clog2(W);
  localparam logic [AW-1:0] AMT_W = AW'(W);

  logic          amt_zero, amt_lt, amt_eq;
  logic [LW-1:0] k, k_neg, k_dec;

  always_comb begin
    amt_zero = (amt == '0);
    amt_lt   = !amt_zero && (amt < AMT_W);
    amt_eq   = (amt == AMT_W);
    k        = amt[LW-1:0];
    k_neg    = LW'(0) - k;
    k_dec    = k - LW'(1);
  end

  always_comb begin
    y    = d;
    cout = cin;
    if (!amt_zero) begin
      unique case (kind)
        SH_LEFT: begin
          if (amt_lt)      begin y = d << k; cout = d[k_neg]; end
          else if (amt_eq) begin y = '0;     cout = d[0];     end
          else             begin y = '0;     cout = 1'b0;     end
        end
        SH_RIGHT: begin
          if (amt_lt)      begin y = d >> k; cout = d[k_dec]; end
          else if (amt_eq) begin y = '0;     cout = d[W-1];   end
          else             begin y = '0;     cout = 1'b0;     end
        end
        SH_ARITH: begin
          if (amt_lt) begin y = W'($signed(d) >>> k); cout = d[k_dec]; end
          else        begin y = {W{d[W-1]}};          cout = d[W-1];   end
        end
        default: begin
          if (k == '0) begin y = d;                        cout = d[W-1]; end
          else         begin y = (d >> k) | (d << k_neg); cout = d[k_dec]; end
        end
      endcase
    end
  end

  always_comb begin
    if (amt_zero) begin
      // R6
      zero_amt_keep_chk: assert (y == d && cout == cin)
        else $error("zero shift amount altered value or carry");
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic         n_i,
  input  logic         z_i,
  input  logic         c_i,
  input  logic         v_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o,
  output logic         mul_req_o
);
  alu_op_e      op;
  logic [W-1:0] lg_y, sh_y, as_a, as_b, as_sum;
  logic         sh_c, as_cin, as_cout, as_ovf;
  shift_kind_e  sh_kind;

  assign op = alu_op_e'(op_i);

  alu_logic #(.W(W)) u_logic (.op(op), .a(dst_i), .b(src_i), .y(lg_y));

  always_comb begin
    unique case (op)
      OPC_LSR: sh_kind = SH_RIGHT;
      OPC_ASR: sh_kind = SH_ARITH;
      OPC_ROR: sh_kind = SH_ROT;
      default: sh_kind = SH_LEFT;
    endcase
  end

  alu_shift #(.W(W), .AW(AW)) u_shift (
    .kind(sh_kind), .d(dst_i), .amt(src_i[AW-1:0]), .cin(c_i),
    .y(sh_y), .cout(sh_c)
  );

  always_comb begin
    as_a   = dst_i;
    as_b   = src_i;
    as_cin = 1'b0;
    unique case (op)
      OPC_ADC: as_cin = c_i;
      OPC_SBC: begin as_b = ~src_i; as_cin = c_i; end
      OPC_NEG: begin as_a = '0; as_b = ~src_i; as_cin = 1'b1; end
      OPC_CMP: begin as_b = ~src_i; as_cin = 1'b1; end
      default: ;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(as_a), .b(as_b), .cin(as_cin),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  always_comb begin
    result_o  = dst_i;
    wr_en_o   = 1'b0;
    mul_req_o = 1'b0;
    n_o = n_i;
    z_o = z_i;
    c_o = c_i;
    v_o = v_i;
    unique case (op)
      OPC_AND, OPC_EOR, OPC_ORR, OPC_BIC, OPC_MVN: begin
        result_o = lg_y;
        wr_en_o  = 1'b1;
        n_o = lg_y[W-1];
        z_o = (lg_y == '0);
      end
      OPC_TST: begin
        n_o = lg_y[W-1];
        z_o = (lg_y == '0);
      end
      OPC_LSL, OPC_LSR, OPC_ASR, OPC_ROR: begin
        result_o = sh_y;
        wr_en_o  = 1'b1;
        n_o = sh_y[W-1];
        z_o = (sh_y == '0);
        c_o = sh_c;
      end
      OPC_ADC, OPC_SBC, OPC_NEG: begin
        result_o = as_sum;
        wr_en_o  = 1'b1;
        n_o = as_sum[W-1];
        z_o = (as_sum == '0);
        c_o = as_cout;
        v_o = as_ovf;
      end
      OPC_CMP, OPC_CMN: begin
        n_o = as_sum[W-1];
        z_o = (as_sum == '0);
        c_o = as_cout;
        v_o = as_ovf;
      end
      default: mul_req_o = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown(op_i)) begin
      // R5
      cmp_no_write_chk: assert (!((op == OPC_TST || op == OPC_CMP || op == OPC_CMN ||
                                   op == OPC_MUL) && wr_en_o))
        else $error("compare or multiply code asserted write");
      // R5
      pass_through_chk: assert (wr_en_o || result_o == dst_i)
        else $error("unwritten result differs from destination");
      // R11
      mul_keep_flags_chk: assert (!mul_req_o ||
                                  (n_o == n_i && z_o == z_i && c_o == c_i && v_o == v_i))
        else $error("multiply request changed flags");
      // R12
      nz_result_chk: assert (!wr_en_o || (n_o == result_o[W-1] && z_o == (result_o == '0)))
        else $error("N/Z disagree with written result");
      // R1
      logic_keep_cv_chk: assert (!(op == OPC_AND || op == OPC_EOR || op == OPC_ORR ||
                                   op == OPC_BIC || op == OPC_MVN || op == OPC_TST) ||
                                 (c_o == c_i && v_o == v_i))
        else $error("logical code changed C or V");
      // R12
      shift_keep_v_chk: assert (!(op == OPC_LSL || op == OPC_LSR || op == OPC_ASR ||
                                  op == OPC_ROR) || v_o == v_i)
        else $error("shift changed V");
    end
  end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op;
  logic [31:0] dst, src;
  logic        ni, zi, ci, vi;
  logic [31:0] res;
  logic        wr, no, zo, co, vo, mreq;
  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #2.5 clk = ~clk;

  alu_core u0 (
    .op_i(op), .dst_i(dst), .src_i(src), .n_i(ni), .z_i(zi), .c_i(ci), .v_i(vi),
    .result_o(res), .wr_en_o(wr), .n_o(no), .z_o(zo), .c_o(co), .v_o(vo),
    .mul_req_o(mreq)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'h0, 4'h1, 4'hC, 4'hE, 4'hF: return "R1";
      4'h8: return "R2";
      4'h5: return "R3";
      4'h6, 4'h9: return "R4";
      4'hA, 4'hB: return "R5";
      4'h2: return "R7";
      4'h3: return "R8";
      4'h4: return "R9";
      4'h7: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Behavioural reference: bit-serial shifts, wide integer arithmetic.
  task automatic model(input logic [3:0] o, input logic [31:0] d, s,
                       input logic fn, fz, fc, fv,
                       output logic [31:0] r, output logic w, en, ez, ec, ev, em);
    longint sd, ss, t;
    longint unsigned u;
    int amt;
    r = d; w = 0; en = fn; ez = fz; ec = fc; ev = fv; em = 0;
    sd = longint'($signed(d)); ss = longint'($signed(s));
    amt = int'(s[7:0]);
    case (o)
      4'h0: begin r = d & s; w = 1; end
      4'h1: begin r = d ^ s; w = 1; end
      4'hC: begin r = d | s; w = 1; end
      4'hE: begin r = d & ~s; w = 1; end
      4'hF: begin r = ~s; w = 1; end
      4'h8: begin en = (d & s) >= 32'h8000_0000; ez = ((d & s) == 0); end
      4'h2, 4'h3, 4'h4, 4'h7: begin
        r = d; w = 1;
        for (int i = 0; i < amt; i++) begin
          case (o)
            4'h2: begin ec = r[31]; r = {r[30:0], 1'b0}; end
            4'h3: begin ec = r[0]; r = {1'b0, r[31:1]}; end
            4'h4: begin ec = r[0]; r = {r[31], r[31:1]}; end
            default: begin ec = r[0]; r = {r[0], r[31:1]}; end
          endcase
        end
      end
      4'h5, 4'hB: begin
        u = longint'(d) + longint'(s) + ((o == 4'h5) ? longint'(fc) : 0);
        r = u[31:0]; ec = u[32];
        t = sd + ss + ((o == 4'h5) ? longint'(fc) : 0);
        ev = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        w = (o == 4'h5);
      end
      4'h6, 4'h9, 4'hA: begin
        if (o == 4'h9) begin u = 0; t = 0 - ss; ec = (s == 0); end
        else if (o == 4'hA) begin t = sd - ss; ec = (d >= s); end
        else begin
          t = sd - ss - (1 - longint'(fc));
          ec = (longint'(d) - longint'(s) - (1 - longint'(fc))) >= 0;
        end
        if (o == 4'h9) r = 32'(0 - s);
        else if (o == 4'hA) r = d - s;
        else r = d - s - {31'd0, ~fc};
        ev = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        w = (o != 4'hA);
      end
      default: em = 1;
    endcase
    if (o != 4'h8 && o != 4'hD) begin
      en = r[31]; ez = (r == 0);
    end
    if (!w) r = d;
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] d, s, input logic [3:0] f);
    logic [31:0] er;
    logic ew, en, ez, ec, ev, em;
    string tg;
    @(posedge clk);
    #1;
    op = o; dst = d; src = s; {ni, zi, ci, vi} = f;
    @(negedge clk);
    model(o, d, s, f[3], f[2], f[1], f[0], er, ew, en, ez, ec, ev, em);
    tg = tag_of(o);
    if (s[7:0] == 8'd0 && (o == 4'h2 || o == 4'h3 || o == 4'h4 || o == 4'h7)) tg = "R6";
    n_tests++;
    if (res !== er || wr !== ew || {no, zo, co, vo} !== {en, ez, ec, ev} || mreq !== em) begin
      n_fail++;
      $display("FAIL %s op=%h d=%h s=%h: got res=%h wr=%b nzcv=%b mul=%b, expected res=%h wr=%b nzcv=%b mul=%b",
               tg, o, d, s, res, wr, {no, zo, co, vo}, mreq, er, ew, {en, ez, ec, ev}, em);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] amts [8];
    amts = '{32'd0, 32'd1, 32'd31, 32'd32, 32'd33, 32'd255, 32'd64, 32'd96};
    rst_n = 1'b0;
    op = 4'h0; dst = '0; src = '0; {ni, zi, ci, vi} = 4'b0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 logical ops keep C and V set
    apply(4'h0, 32'hF0F0_FFFF, 32'h0F0F_0000, 4'b0011);
    apply(4'hF, 32'h1234_5678, 32'h0000_0000, 4'b0011);
    apply(4'hE, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 4'b0001);
    // R2 TST zero result, no write
    apply(4'h8, 32'hAAAA_AAAA, 32'h5555_5555, 4'b1011);
    // R3 ADC carry and overflow
    apply(4'h5, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0010);
    apply(4'h5, 32'h7FFF_FFFF, 32'h0000_0001, 4'b0000);
    // R4 SBC borrow, NEG of zero and of min
    apply(4'h6, 32'h0000_0005, 32'h0000_0005, 4'b0000);
    apply(4'h9, 32'h1111_1111, 32'h0000_0000, 4'b0000);
    apply(4'h9, 32'h0, 32'h8000_0000, 4'b0000);
    // R5 compares do not write
    apply(4'hA, 32'h8000_0000, 32'h0000_0001, 4'b0000);
    apply(4'hB, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0000);
    // R6 amount zero with upper src bits set (ignored)
    apply(4'h2, 32'h8000_0001, 32'hFFFF_FF00, 4'b0010);
    apply(4'h7, 32'h8000_0001, 32'h1234_5600, 4'b0000);
    // R7 R8 R9 R10 boundary amounts
    apply(4'h2, 32'h0000_0001, 32'd32, 4'b0000);
    apply(4'h2, 32'hFFFF_FFFF, 32'd33, 4'b0010);
    apply(4'h3, 32'h8000_0000, 32'd32, 4'b0000);
    apply(4'h4, 32'h8000_0000, 32'd200, 4'b0000);
    apply(4'h7, 32'h8000_0000, 32'd64, 4'b0000);
    apply(4'h7, 32'h0000_0003, 32'd33, 4'b0000);
    // R11 multiply request
    apply(4'hD, 32'h0000_0003, 32'h0000_0004, 4'b1010);
    // sweep every opcode with varied operands and shift amounts
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d, s;
      lfsr = step(lfsr); d = lfsr;
      lfsr = step(lfsr); s = lfsr;
      if (i % 3 == 0) s = {s[31:8], amts[i % 8][7:0]};
      if (i % 7 == 0) d = {d[31], 31'd0};
      apply(4'(i % 16), d, s, lfsr[3:0]);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule